// File: doc/BRIEF.md
# Display Controller Command Byte Parser

This block sits behind the byte assembler of a serial link to a small grey-scale display controller. It consumes one byte per `byte_vld` strobe while chip select is high. A select line sorts each byte into one of two streams: command bytes or pixel data bytes. In the command stream, the first byte of each command is an opcode. A fixed decode table gives the number of argument bytes that opcode expects. The block buffers those argument bytes and, when the last one arrives, executes the command in the same clock edge.

Three commands change visible state:
- the column window;
- the row window;
- the remap byte.

Window arguments are reduced modulo the display RAM width or height before they are stored. Every other known opcode has its argument bytes consumed and discarded. An unknown opcode is consumed alone and flags a one-cycle error.

In the data stream, each byte goes out as a registered RAM write. The write address is built from a column/row cursor. After each write the cursor steps inside the current windows. The step is column-first or row-first, chosen by bit 2 of the remap byte.

Top module: `oled_cmd_parser`

## Requirements
- R1: A byte is accepted when `byte_vld` and `cs` are both high. It is a data byte when `dc_sel` is 1 and a command byte when `dc_sel` is 0. Data bytes never change `col_start`, `col_end`, `row_start`, `row_end` or `remap`.
- R2: Opcode 0x15 takes two arguments, a and b. On the edge that accepts b:
  - `col_start` becomes a mod COL_CNT;
  - `col_end` becomes b mod COL_CNT;
  - the column cursor moves to `col_start`.
- R3: Opcode 0x75 takes two arguments, a and b. On the edge that accepts b:
  - `row_start` becomes a mod ROW_CNT;
  - `row_end` becomes b mod ROW_CNT;
  - the row cursor moves to `row_start`.
- R4: Opcode 0xA0 takes one argument, which is stored unchanged in `remap`.
- R5: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each swallow exactly one argument byte and change nothing. The byte after that argument is taken as a new opcode.
- R6: Opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 take no argument and change nothing. The next command byte is a new opcode.
- R7: Opcode 0xB8 swallows exactly eight argument bytes and changes nothing.
- R8: Any other opcode takes no argument. `bad_op` is high for exactly the one cycle after the edge that accepted it.
- R9: While `cs` is low, strobed bytes are ignored: no write and no state change. A command left partly collected when `cs` drops is abandoned, so the next command byte is an opcode.
- R10: A data byte produces, in the following cycle:
  - `ram_we` = 1;
  - `ram_wdata` = the byte;
  - `ram_addr` = row*COL_CNT + col, using the cursor position before the step.

  With `remap` bit 2 = 0, the cursor then steps as follows. The column increments; if it exceeds `col_end`, the column returns to `col_start` and the row increments. Independently of that, if the row exceeds `row_end`, the row returns to `row_start`.
- R11: With `remap` bit 2 = 1, the step is row-first. The row increments; if it exceeds `row_end`, the row returns to `row_start` and the column increments. If the column exceeds `col_end`, the column returns to `col_start`.
- R12: After reset:
  - `col_start` = 0 and `col_end` = COL_CNT-1;
  - `row_start` = 0 and `row_end` = ROW_CNT-1;
  - `remap` = 0 and the cursor is at 0,0;
  - `ram_we`, `ram_addr`, `ram_wdata` and `bad_op` are all 0.
- R13: Data bytes arriving between the argument bytes of a command do not disturb argument collection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| dc_sel | input | 1 | 1 = data byte, 0 = command byte |
| byte_vld | input | 1 | One-cycle strobe marking a received byte |
| byte_in | input | 8 | Received byte |
| col_start | output | $clog2(COL_CNT) | Column window start |
| col_end | output | $clog2(COL_CNT) | Column window end |
| row_start | output | $clog2(ROW_CNT) | Row window start |
| row_end | output | $clog2(ROW_CNT) | Row window end |
| remap | output | 8 | Remap byte; bit 2 selects row-first stepping |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | $clog2(COL_CNT*ROW_CNT) | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |
| bad_op | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
The bench builds the parser with COL_CNT = 16 and ROW_CNT = 12, not the default 64 by 80. At that size, nearly every argument byte lands above the modulus, and the non-power-of-two row count exercises a real remainder rather than bit truncation. A full-window sweep of 192 writes is also short enough to run past both wraps of the cursor, in both stepping orders. Windows with start greater than end, `cs` drops in the middle of a command, and data bytes interleaved with arguments all arise in the random phase.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;

  typedef enum logic [2:0] {
    OP_COLWIN,
    OP_ROWWIN,
    OP_REMAP,
    OP_SINK,
    OP_BAD
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [3:0] nargs;
  } op_info_t;

  // Opcode decode table: what the opcode does and how many argument bytes follow.
  function automatic op_info_t classify(input logic [7:0] op);
    op_info_t r;
    r.kind  = OP_SINK;
    r.nargs = 4'd0;
    case (op)
      8'h15: begin r.kind = OP_COLWIN; r.nargs = 4'd2; end
      8'h75: begin r.kind = OP_ROWWIN; r.nargs = 4'd2; end
      8'hA0: begin r.kind = OP_REMAP;  r.nargs = 4'd1; end
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
        r.nargs = 4'd1;
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3:
        r.nargs = 4'd0;
      8'hB8: r.nargs = 4'd8;
      default: r.kind = OP_BAD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/oled_arg_collect.sv
module oled_arg_collect
  import oled_cmd_pkg::*;
#(
  parameter int MAX_ARGS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cs,
  input  logic                         take_cmd,
  input  logic [7:0]                   byte_in,
  output logic                         exec_vld,
  output op_kind_e                     exec_kind,
  output logic [MAX_ARGS-1:0][7:0]     exec_args,
  output logic                         bad_op
);
  localparam int CW = $clog2(MAX_ARGS + 1);

  logic [CW-1:0]               cnt_q;
  logic [7:0]                  op_q;
  logic [MAX_ARGS-1:0][7:0]    args_q;
  op_info_t                    first_info;
  op_info_t                    held_info;

  assign first_info = classify(byte_in);
  assign held_info  = classify(op_q);

  // Merge the incoming argument so a command can execute on its last byte.
  always_comb begin
    exec_vld  = 1'b0;
    exec_kind = held_info.kind;
    exec_args = args_q;
    if (take_cmd) begin
      if (cnt_q == '0) begin
        if (first_info.nargs == 4'd0) begin
          exec_vld  = 1'b1;
          exec_kind = first_info.kind;
        end
      end else begin
        for (int i = 0; i < MAX_ARGS; i++) begin
          if (int'(cnt_q) == i + 1) exec_args[i] = byte_in;
        end
        if (int'(cnt_q) == int'(held_info.nargs)) exec_vld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs) begin
      cnt_q <= '0;
    end else if (take_cmd) begin
      if (cnt_q == '0) begin
        cnt_q <= (first_info.nargs == 4'd0) ? '0 : CW'(1);
      end else begin
        cnt_q <= exec_vld ? '0 : cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= 8'h00;
      args_q <= '0;
      bad_op <= 1'b0;
    end else begin
      bad_op <= take_cmd && (cnt_q == '0) && (first_info.kind == OP_BAD);
      if (take_cmd && cnt_q == '0) op_q <= byte_in;
      if (take_cmd && cnt_q != '0) args_q <= exec_args;
    end
  end

endmodule

// File: rtl/oled_window_regs.sv
module oled_window_regs
  import oled_cmd_pkg::*;
#(
  parameter int COL_CNT  = 64,
  parameter int ROW_CNT  = 80,
  parameter int MAX_ARGS = 8,
  localparam int CAW = $clog2(COL_CNT),
  localparam int RAW = $clog2(ROW_CNT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     exec_vld,
  input  op_kind_e                 exec_kind,
  input  logic [MAX_ARGS-1:0][7:0] exec_args,
  output logic [CAW-1:0]           col_start,
  output logic [CAW-1:0]           col_end,
  output logic [RAW-1:0]           row_start,
  output logic [RAW-1:0]           row_end,
  output logic [7:0]               remap,
  output logic                     col_load,
  output logic [CAW-1:0]           col_val,
  output logic                     row_load,
  output logic [RAW-1:0]           row_val
);
  logic [CAW-1:0] col_b;
  logic [RAW-1:0] row_b;
  logic           unused_args;

  assign unused_args = ^exec_args[MAX_ARGS-1:2];

  assign col_val = CAW'(int'(exec_args[0]) % COL_CNT);
  assign col_b   = CAW'(int'(exec_args[1]) % COL_CNT);
  assign row_val = RAW'(int'(exec_args[0]) % ROW_CNT);
  assign row_b   = RAW'(int'(exec_args[1]) % ROW_CNT);

  assign col_load = exec_vld && (exec_kind == OP_COLWIN);
  assign row_load = exec_vld && (exec_kind == OP_ROWWIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_start <= '0;
      col_end   <= CAW'(COL_CNT - 1);
      row_start <= '0;
      row_end   <= RAW'(ROW_CNT - 1);
      remap     <= 8'h00;
    end else if (exec_vld) begin
      case (exec_kind)
        OP_COLWIN: begin col_start <= col_val; col_end <= col_b; end
        OP_ROWWIN: begin row_start <= row_val; row_end <= row_b; end
        OP_REMAP:  remap <= exec_args[0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/oled_cursor.sv
module oled_cursor #(
  parameter int COL_CNT = 64,
  parameter int ROW_CNT = 80,
  localparam int CAW = $clog2(COL_CNT),
  localparam int RAW = $clog2(ROW_CNT),
  localparam int AW  = $clog2(COL_CNT * ROW_CNT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           col_load,
  input  logic [CAW-1:0] col_val,
  input  logic           row_load,
  input  logic [RAW-1:0] row_val,
  input  logic           step,
  input  logic           vertical,
  input  logic [CAW-1:0] col_start,
  input  logic [CAW-1:0] col_end,
  input  logic [RAW-1:0] row_start,
  input  logic [RAW-1:0] row_end,
  input  logic [7:0]     byte_in,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic [7:0]     ram_wdata
);
  logic [CAW-1:0] col_q;
  logic [RAW-1:0] row_q;
  int             nc;
  int             nr;

  always_comb begin
    nc = int'(col_q);
    nr = int'(row_q);
    if (vertical) begin
      nr = nr + 1;
      if (nr > int'(row_end)) begin
        nr = int'(row_start);
        nc = nc + 1;
      end
      if (nc > int'(col_end)) nc = int'(col_start);
    end else begin
      nc = nc + 1;
      if (nc > int'(col_end)) begin
        nc = int'(col_start);
        nr = nr + 1;
      end
      if (nr > int'(row_end)) nr = int'(row_start);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q     <= '0;
      row_q     <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= 8'h00;
    end else begin
      ram_we <= step;
      if (step) begin
        ram_addr  <= AW'(int'(row_q) * COL_CNT + int'(col_q));
        ram_wdata <= byte_in;
        col_q     <= CAW'(nc);
        row_q     <= RAW'(nr);
      end else begin
        if (col_load) col_q <= col_val;
        if (row_load) row_q <= row_val;
      end
    end
  end

endmodule

// File: rtl/oled_cmd_parser.sv
module oled_cmd_parser
  import oled_cmd_pkg::*;
#(
  parameter int COL_CNT  = 64,
  parameter int ROW_CNT  = 80,
  parameter int MAX_ARGS = 8,
  localparam int CAW = $clog2(COL_CNT),
  localparam int RAW = $clog2(ROW_CNT),
  localparam int AW  = $clog2(COL_CNT * ROW_CNT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs,
  input  logic           dc_sel,
  input  logic           byte_vld,
  input  logic [7:0]     byte_in,
  output logic [CAW-1:0] col_start,
  output logic [CAW-1:0] col_end,
  output logic [RAW-1:0] row_start,
  output logic [RAW-1:0] row_end,
  output logic [7:0]     remap,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic [7:0]     ram_wdata,
  output logic           bad_op
);
  logic                     take_cmd;
  logic                     take_data;
  logic                     exec_vld;
  op_kind_e                 exec_kind;
  logic [MAX_ARGS-1:0][7:0] exec_args;
  logic                     col_load;
  logic                     row_load;
  logic [CAW-1:0]           col_val;
  logic [RAW-1:0]           row_val;

  assign take_cmd  = byte_vld && cs && !dc_sel;
  assign take_data = byte_vld && cs && dc_sel;

  oled_arg_collect #(.MAX_ARGS(MAX_ARGS)) u_collect (
    .clk(clk), .rst(rst), .cs(cs), .take_cmd(take_cmd), .byte_in(byte_in),
    .exec_vld(exec_vld), .exec_kind(exec_kind), .exec_args(exec_args),
    .bad_op(bad_op)
  );

  oled_window_regs #(.COL_CNT(COL_CNT), .ROW_CNT(ROW_CNT), .MAX_ARGS(MAX_ARGS)) u_win (
    .clk(clk), .rst(rst), .exec_vld(exec_vld), .exec_kind(exec_kind),
    .exec_args(exec_args),
    .col_start(col_start), .col_end(col_end),
    .row_start(row_start), .row_end(row_end), .remap(remap),
    .col_load(col_load), .col_val(col_val),
    .row_load(row_load), .row_val(row_val)
  );

  oled_cursor #(.COL_CNT(COL_CNT), .ROW_CNT(ROW_CNT)) u_cursor (
    .clk(clk), .rst(rst),
    .col_load(col_load), .col_val(col_val),
    .row_load(row_load), .row_val(row_val),
    .step(take_data), .vertical(remap[2]),
    .col_start(col_start), .col_end(col_end),
    .row_start(row_start), .row_end(row_end),
    .byte_in(byte_in),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

endmodule

// File: rtl/oled_cmd_parser_chk.sv
module oled_cmd_parser_chk #(
  parameter int COL_CNT = 64,
  parameter int ROW_CNT = 80,
  localparam int CAW = $clog2(COL_CNT),
  localparam int RAW = $clog2(ROW_CNT),
  localparam int AW  = $clog2(COL_CNT * ROW_CNT)
) (
  input logic           clk,
  input logic           rst,
  input logic           cs,
  input logic           dc_sel,
  input logic           byte_vld,
  input logic [CAW-1:0] col_start,
  input logic [CAW-1:0] col_end,
  input logic [RAW-1:0] row_start,
  input logic [RAW-1:0] row_end,
  input logic [7:0]     remap,
  input logic           ram_we,
  input logic [AW-1:0]  ram_addr,
  input logic           bad_op
);

  a_r3_row_in_range: assert property (@(posedge clk) disable iff (rst)
    (int'(row_start) < ROW_CNT) && (int'(row_end) < ROW_CNT));

  a_r1_data_keeps_windows: assert property (@(posedge clk) disable iff (rst)
    $past(dc_sel) |-> $stable({col_start, col_end, row_start, row_end, remap}));

  a_r8_bad_follows_cmd: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> $past(byte_vld && cs && !dc_sel));

  a_r10_we_follows_data: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(byte_vld && cs && dc_sel));

  a_r10_addr_in_ram: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (int'(ram_addr) < COL_CNT * ROW_CNT));

  a_r9_idle_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !$past(cs) |-> (!ram_we && !bad_op &&
                    $stable({col_start, col_end, row_start, row_end, remap})));

endmodule

bind oled_cmd_parser oled_cmd_parser_chk #(.COL_CNT(COL_CNT), .ROW_CNT(ROW_CNT)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .dc_sel(dc_sel), .byte_vld(byte_vld),
  .col_start(col_start), .col_end(col_end), .row_start(row_start),
  .row_end(row_end), .remap(remap), .ram_we(ram_we), .ram_addr(ram_addr),
  .bad_op(bad_op)
);

// File: tb/oled_cmd_parser_bench.sv
module oled_cmd_parser_bench;
  localparam int C   = 16;
  localparam int R   = 12;
  localparam int CAW = $clog2(C);
  localparam int RAW = $clog2(R);
  localparam int AW  = $clog2(C * R);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0;
  logic dc_sel = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [CAW-1:0] col_start, col_end;
  logic [RAW-1:0] row_start, row_end;
  logic [7:0] remap;
  logic ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic bad_op;

  always #10 clk = ~clk;

  oled_cmd_parser #(.COL_CNT(C), .ROW_CNT(R)) u_oled_cmd_parser (
    .clk(clk), .rst(rst), .cs(cs), .dc_sel(dc_sel), .byte_vld(byte_vld),
    .byte_in(byte_in), .col_start(col_start), .col_end(col_end),
    .row_start(row_start), .row_end(row_end), .remap(remap),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .bad_op(bad_op)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model
  int m_cnt, m_op, m_nargs;
  int m_cs0, m_ce, m_rs, m_re, m_remap, m_col, m_row;
  int m_we, m_addr, m_wd, m_bad;
  int m_args[$];

  function automatic int nargs_of(input int op);
    case (op)
      'h15, 'h75: return 2;
      'hA0, 'h81, 'hA1, 'hA2, 'hA8, 'hAD, 'hB1, 'hB2, 'hB3, 'hBC, 'hBE, 'hBF: return 1;
      'h84, 'h85, 'h86, 'hA4, 'hA5, 'hA6, 'hA7, 'hAE, 'hAF, 'hE3: return 0;
      'hB8: return 8;
      default: return -1;
    endcase
  endfunction

  task automatic m_exec();
    if (m_op == 'h15) begin
      m_cs0 = m_args[0] % C; m_ce = m_args[1] % C; m_col = m_cs0;
    end else if (m_op == 'h75) begin
      m_rs = m_args[0] % R; m_re = m_args[1] % R; m_row = m_rs;
    end else if (m_op == 'hA0) begin
      m_remap = m_args[0];
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_op = 0; m_nargs = 0;
      m_cs0 = 0; m_ce = C - 1; m_rs = 0; m_re = R - 1; m_remap = 0;
      m_col = 0; m_row = 0; m_we = 0; m_addr = 0; m_wd = 0; m_bad = 0;
      m_args.delete();
    end else begin
      m_we = 0; m_bad = 0;
      if (!cs) begin
        m_cnt = 0;
      end else if (byte_vld && dc_sel) begin
        m_we = 1; m_addr = m_row * C + m_col; m_wd = byte_in;
        if (m_remap[2]) begin
          m_row++;
          if (m_row > m_re) begin m_row = m_rs; m_col++; end
          if (m_col > m_ce) m_col = m_cs0;
        end else begin
          m_col++;
          if (m_col > m_ce) begin m_col = m_cs0; m_row++; end
          if (m_row > m_re) m_row = m_rs;
        end
      end else if (byte_vld) begin
        if (m_cnt == 0) begin
          m_op = byte_in; m_nargs = nargs_of(m_op); m_args.delete();
          if (m_nargs < 0) m_bad = 1;
          else if (m_nargs == 0) m_exec();
          else m_cnt = 1;
        end else begin
          m_args.push_back(int'(byte_in));
          if (m_args.size() == m_nargs) begin m_exec(); m_cnt = 0; end
          else m_cnt++;
        end
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 col_start", int'(col_start), m_cs0);
      chk("R2 col_end", int'(col_end), m_ce);
      chk("R3 row_start", int'(row_start), m_rs);
      chk("R3 row_end", int'(row_end), m_re);
      chk("R4 remap", int'(remap), m_remap);
      chk("R10 ram_we", int'(ram_we), m_we);
      if (m_we != 0) begin
        chk("R10 ram_addr", int'(ram_addr), m_addr);
        chk("R10 ram_wdata", int'(ram_wdata), m_wd);
      end
      chk("R8 bad_op", int'(bad_op), m_bad);
    end
  end

  task automatic send(input bit dc, input logic [7:0] b);
    @(negedge clk);
    dc_sel = dc; byte_in = b; byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 col_end reset", int'(col_end), C - 1);
    chk("R12 row_end reset", int'(row_end), R - 1);
    chk("R12 col_start reset", int'(col_start), 0);
    chk("R12 remap reset", int'(remap), 0);
    chk("R12 ram_we reset", int'(ram_we), 0);
    chk("R12 bad_op reset", int'(bad_op), 0);
    cs = 1'b1;

    // R2 modulo column window
    send(0, 8'h15); send(0, 8'h25); send(0, 8'h13);
    chk("R2 col_start mod", int'(col_start), 5);
    chk("R2 col_end mod", int'(col_end), 3);
    // R3 modulo row window
    send(0, 8'h75); send(0, 8'h0E); send(0, 8'h1B);
    chk("R3 row_start mod", int'(row_start), 2);
    chk("R3 row_end mod", int'(row_end), 3);

    // R10 horizontal stepping
    send(0, 8'h15); send(0, 8'h02); send(0, 8'h04);
    send(0, 8'h75); send(0, 8'h01); send(0, 8'h02);
    send(1, 8'h5A);
    chk("R10 first addr", int'(ram_addr), 18);
    chk("R10 wdata", int'(ram_wdata), 'h5A);
    send(1, 8'h01);
    chk("R10 second addr", int'(ram_addr), 19);
    for (int i = 0; i < 8; i++) send(1, 8'(i));

    // R4 remap, R11 vertical stepping
    send(0, 8'hA0); send(0, 8'h04);
    chk("R4 remap value", int'(remap), 4);
    send(0, 8'h15); send(0, 8'h02); send(0, 8'h04);
    send(0, 8'h75); send(0, 8'h01); send(0, 8'h02);
    send(1, 8'h11);
    chk("R11 first addr", int'(ram_addr), 18);
    send(1, 8'h22);
    chk("R11 second addr", int'(ram_addr), 34);
    for (int i = 0; i < 8; i++) send(1, 8'(i + 3));

    // R5 one-argument sink
    send(0, 8'h81); send(0, 8'h15);
    chk("R5 col unchanged", int'(col_end), 4);
    send(0, 8'h75); send(0, 8'h00); send(0, 8'h05);
    chk("R5 next is opcode", int'(row_end), 5);
    // R6 zero-argument
    send(0, 8'hA4); send(0, 8'h15); send(0, 8'h03); send(0, 8'h06);
    chk("R6 next is opcode", int'(col_end), 6);
    // R7 eight arguments
    send(0, 8'hB8);
    send(0, 8'h15); send(0, 8'h75); send(0, 8'hA0); send(0, 8'h07);
    send(0, 8'h07); send(0, 8'h07); send(0, 8'h07); send(0, 8'h07);
    chk("R7 col unchanged", int'(col_start), 3);
    chk("R7 remap unchanged", int'(remap), 4);
    send(0, 8'hA0); send(0, 8'h00);
    chk("R7 next is opcode", int'(remap), 0);

    // R8 unknown opcode pulse
    send(0, 8'h00);
    chk("R8 pulse high", int'(bad_op), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(bad_op), 0);
    send(0, 8'h15); send(0, 8'h01); send(0, 8'h01);
    chk("R8 next is opcode", int'(col_end), 1);

    // R9 chip select drop
    send(0, 8'h15); send(0, 8'h09);
    cs = 1'b0;
    send(1, 8'hEE);
    chk("R9 no write deselected", int'(ram_we), 0);
    send(0, 8'h75);
    cs = 1'b1;
    send(0, 8'h75); send(0, 8'h04); send(0, 8'h04);
    chk("R9 row after abandon", int'(row_end), 4);
    chk("R9 col untouched", int'(col_start), 1);

    // R13 data between arguments, R1 data leaves windows
    send(0, 8'h15); send(1, 8'hAA); send(0, 8'h0A); send(1, 8'hBB); send(0, 8'h0B);
    chk("R13 col_start", int'(col_start), 10);
    chk("R13 col_end", int'(col_end), 11);
    send(1, 8'h15);
    chk("R1 data no window change", int'(col_start), 10);

    // Full-window sweep in both orders
    send(0, 8'h15); send(0, 8'h00); send(0, 8'h0F);
    send(0, 8'h75); send(0, 8'h00); send(0, 8'h0B);
    for (int i = 0; i < C * R + 3; i++) send(1, 8'(i));
    send(0, 8'hA0); send(0, 8'h04);
    for (int i = 0; i < C * R + 3; i++) send(1, 8'(i));

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] b;
      r = int'($urandom_range(0, 99));
      cs = (r < 4) ? 1'b0 : 1'b1;
      case ($urandom_range(0, 5))
        0: b = 8'h15;
        1: b = 8'h75;
        2: b = 8'hA0;
        3: b = 8'hB8;
        default: b = 8'($urandom);
      endcase
      send(r > 60, b);
    end
    cs = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule